// File: doc/BRIEF.md
# Seven-Channel DMA Request Arbiter

This block is the host-side front end of a DMA controller with seven request channels. Each request line arrives asynchronously and passes through a two-stage synchroniser. When the sequencer is idle, it picks the pending and enabled channel with the lowest index. It then runs a transfer of fixed length. For that whole transfer it drives the address-enable and address-latch outputs high and pulls the granted channel's active-low acknowledge.

Each channel holds a block counter that is loaded through a small write port. Each granted transfer uses up one count. The transfer that empties the counter is flagged by raising the terminal-count output for its full duration. After that, the channel ignores its request until it is loaded again. Between two transfers the sequencer always spends at least one idle cycle. It makes a new choice only in that idle cycle, so a transfer in progress is never pre-empted.

Top module: `dma_req_arb`

## Requirements
- R1: A request driven high just after a clock edge reaches the arbiter through two synchronising flops. If the sequencer is idle and the channel is enabled, the transfer outputs rise after the third rising edge that follows.
- R2: When several enabled channels are requesting at the arbitration point, the channel with the lowest index (bit 0 of `dreq_i`) is granted.
- R3: During a transfer, exactly one bit of `dack_no` is low, and it is the bit of the granted channel.
- R4: `aen_o` and `bale_o` are both high for exactly `XFER_CYCLES` consecutive cycles per transfer.
- R5: Outside a transfer and during reset, `dack_no` is all ones and `aen_o`, `bale_o` and `tc_o` are low.
- R6: Arbitration takes place only while idle. A request from a higher-priority channel that rises during a transfer leaves that transfer's acknowledge unchanged and is served by the next transfer.
- R7: A write with `cfg_we_i` high loads `cfg_count_i` into the counter of channel `cfg_chan_i`. A non-zero value enables the channel. Zero disables it, and a disabled channel's request never starts a transfer.
- R8: `tc_o` is high for every cycle of the transfer that takes a channel's count from one to zero, and low in all other transfers.
- R9: After its final counted transfer, a channel is not granted again while its request stays high, until it is reloaded.
- R10: Two transfers are always separated by at least one cycle with `aen_o` low.
- R11: After reset, all channel counters are zero, so no request is served before a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dreq_i | input | NCH | Asynchronous request lines, bit 0 highest priority |
| cfg_we_i | input | 1 | Counter load strobe |
| cfg_chan_i | input | $clog2(NCH) | Channel selected for the load |
| cfg_count_i | input | CNT_W | Number of transfers in the block (0 disables) |
| aen_o | output | 1 | Address enable, high while the DMA side owns the bus |
| bale_o | output | 1 | Address latch enable, forced high during a transfer |
| dack_no | output | NCH | Active-low acknowledge, one bit per channel |
| tc_o | output | 1 | Terminal count, high throughout the final transfer of a block |

## Verification
The checker assumes that requests are level signals that stay high until the requester sees its acknowledge. It also assumes that loads name a channel index below NCH. Under those assumptions, the acknowledge vector, the transfer length and the terminal-count flag depend only on the sequencer state. The stimulus changes requests and load strobes only on falling clock edges. It drops or changes a request only after the transfer outputs have been observed high, and it never loads a channel while that channel's transfer is running.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } dma_state_e;

endpackage

// File: rtl/dma_req_sync.sv
// Two-flop synchroniser, one lane per request line.
module dma_req_sync #(
  parameter int NCH = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] async_i,
  output logic [NCH-1:0] sync_o
);

  logic [NCH-1:0] stg1_q;
  logic [NCH-1:0] stg2_q;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg1_q[g] <= 1'b0;
        stg2_q[g] <= 1'b0;
      end else begin
        stg1_q[g] <= async_i[g];
        stg2_q[g] <= stg1_q[g];
      end
    end
  end

  assign sync_o = stg2_q;

endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: lowest set index wins.
module dma_prio_pick #(
  parameter int NCH   = 7,
  parameter int IDX_W = 3
) (
  input  logic [NCH-1:0]   req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);

  always_comb begin
    vld_o = |req_i;
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dma_chan_cnt.sv
// Per-channel block counter; load has precedence over consume.
module dma_chan_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             use_i,
  output logic             en_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = 1'b0;
    cnt_d  = cnt_q;
    if (ld_i) begin
      cnt_ce = 1'b1;
      cnt_d  = ld_val_i;
    end else if (use_i && (cnt_q != '0)) begin
      cnt_ce = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign en_o   = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH         = 7,
  parameter int CNT_W       = 8,
  parameter int XFER_CYCLES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NCH-1:0]         dreq_i,
  input  logic                   cfg_we_i,
  input  logic [$clog2(NCH)-1:0] cfg_chan_i,
  input  logic [CNT_W-1:0]       cfg_count_i,
  output logic                   aen_o,
  output logic                   bale_o,
  output logic [NCH-1:0]         dack_no,
  output logic                   tc_o
);

  localparam int IDX_W = $clog2(NCH);
  localparam int CYC_W = $clog2(XFER_CYCLES + 1);

  logic [NCH-1:0]   dreq_s;
  logic [NCH-1:0]   chan_en;
  logic [NCH-1:0]   chan_last;
  logic [NCH-1:0]   chan_ld;
  logic [NCH-1:0]   chan_use;
  logic [NCH-1:0]   eligible;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;

  dma_state_e       state_q, state_d;
  logic [IDX_W-1:0] gnt_q, gnt_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             tc_q, tc_d;
  logic             seq_ce;

  dma_req_sync #(.NCH(NCH)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (dreq_i),
    .sync_o  (dreq_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan_ld[g] = cfg_we_i && (cfg_chan_i == IDX_W'(g));

    dma_chan_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (chan_ld[g]),
      .ld_val_i (cfg_count_i),
      .use_i    (chan_use[g]),
      .en_o     (chan_en[g]),
      .last_o   (chan_last[g])
    );
  end

  assign eligible = dreq_s & chan_en;

  dma_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) pick_i (
    .req_i (eligible),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  // Next-state logic of the transfer sequencer.
  always_comb begin
    state_d  = state_q;
    gnt_d    = gnt_q;
    cyc_d    = cyc_q;
    tc_d     = tc_q;
    seq_ce   = 1'b0;
    chan_use = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_vld) begin
          seq_ce  = 1'b1;
          state_d = ST_XFER;
          gnt_d   = pick_idx;
          cyc_d   = CYC_W'(XFER_CYCLES - 1);
          tc_d    = 1'b0;
          for (int i = 0; i < NCH; i++) begin
            if (pick_idx == IDX_W'(i)) begin
              chan_use[i] = 1'b1;
              tc_d        = chan_last[i];
            end
          end
        end
      end
      ST_XFER: begin
        seq_ce = 1'b1;
        if (cyc_q == '0) begin
          state_d = ST_IDLE;
          tc_d    = 1'b0;
        end else begin
          cyc_d = cyc_q - 1'b1;
        end
      end
      default: begin
        seq_ce  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      cyc_q   <= '0;
      tc_q    <= 1'b0;
    end else if (seq_ce) begin
      state_q <= state_d;
      gnt_q   <= gnt_d;
      cyc_q   <= cyc_d;
      tc_q    <= tc_d;
    end
  end

  assign aen_o  = (state_q == ST_XFER);
  assign bale_o = (state_q == ST_XFER);
  assign tc_o   = tc_q;

  always_comb begin
    dack_no = '1;
    for (int i = 0; i < NCH; i++) begin
      if ((state_q == ST_XFER) && (gnt_q == IDX_W'(i))) dack_no[i] = 1'b0;
    end
  end

endmodule

// File: rtl/dma_req_arb_chk.sv
module dma_req_arb_chk #(
  parameter int NCH         = 7,
  parameter int XFER_CYCLES = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           aen_o,
  input logic           bale_o,
  input logic [NCH-1:0] dack_no,
  input logic           tc_o
);

  localparam int CW = $clog2(XFER_CYCLES + 1);

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
    end else if (!aen_o) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q != CW'(XFER_CYCLES)) begin
      hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // R3
  dack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no));

  // R5
  dack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_no != '1) == aen_o);

  // R4
  bale_with_aen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o == bale_o);

  // R4
  xfer_len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> (hi_cnt_q < CW'(XFER_CYCLES)));

  // R4
  xfer_len_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aen_o && $past(aen_o)) |-> ($past(hi_cnt_q) == CW'(XFER_CYCLES - 1)));

  // R6
  dack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aen_o && $past(aen_o)) |-> $stable(dack_no));

  // R8
  tc_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> aen_o);

  // R8
  tc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aen_o && $past(aen_o)) |-> $stable(tc_o));

endmodule

bind dma_req_arb dma_req_arb_chk #(
  .NCH         (NCH),
  .XFER_CYCLES (XFER_CYCLES)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .aen_o   (aen_o),
  .bale_o  (bale_o),
  .dack_no (dack_no),
  .tc_o    (tc_o)
);

// File: tb/dma_req_arb_tb_top.sv
module dma_req_arb_tb_top;

  localparam int NCH   = 7;
  localparam int CNT_W = 8;
  localparam int XLEN  = 4;

  // {request pattern, expected winner}
  localparam logic [9:0] VEC [8] = '{
    {7'b0000001, 3'd0}, {7'b1000000, 3'd6}, {7'b1010000, 3'd4},
    {7'b0101010, 3'd1}, {7'b1111111, 3'd0}, {7'b1100000, 3'd5},
    {7'b0001100, 3'd2}, {7'b0001000, 3'd3}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   dreq;
  logic             cfg_we;
  logic [2:0]       cfg_chan;
  logic [CNT_W-1:0] cfg_count;
  logic             aen, bale, tc;
  logic [NCH-1:0]   dack_n;

  int nchk  = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  dma_req_arb #(.NCH(NCH), .CNT_W(CNT_W), .XFER_CYCLES(XLEN)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dreq_i      (dreq),
    .cfg_we_i    (cfg_we),
    .cfg_chan_i  (cfg_chan),
    .cfg_count_i (cfg_count),
    .aen_o       (aen),
    .bale_o      (bale),
    .dack_no     (dack_n),
    .tc_o        (tc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int ch, input int val);
    cfg_chan  = 3'(ch);
    cfg_count = CNT_W'(val);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Waits for a transfer; at its first cycle drives dreq to start_req.
  task automatic run_xfer(input logic [NCH-1:0] start_req, output int lat,
                          output logic [NCH-1:0] first_dack, output int len,
                          output bit tc_first, output bit steady);
    lat = 0;
    len = 0;
    steady = 1'b1;
    first_dack = '1;
    tc_first = 1'b0;
    while (!aen && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    if (aen) begin
      first_dack = dack_n;
      tc_first   = tc;
      dreq       = start_req;
      while (aen && len < 30) begin
        len++;
        if (dack_n != first_dack || tc != tc_first || !bale) steady = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (aen || dack_n != '1) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lat, len;
    logic [NCH-1:0] fd;
    bit tcf, st;

    rst_n = 1'b0; dreq = '0; cfg_we = 1'b0; cfg_chan = '0; cfg_count = '0;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(dack_n == '1 && !aen && !bale && !tc, "R5 reset outputs",
        {dack_n, aen, bale, tc}, {7'h7f, 3'b000});
    rst_n = 1'b1;
    @(negedge clk);

    // R11: nothing enabled after reset
    dreq = '1;
    quiet(12, "R11 no grant before load");
    dreq = '0;
    repeat (4) @(negedge clk);

    for (int c = 0; c < NCH; c++) load(c, 100);

    // Table walk: R1, R2, R3, R4
    for (int v = 0; v < 8; v++) begin
      dreq = VEC[v][9:3];
      run_xfer('0, lat, fd, len, tcf, st);
      chk(lat == 3, "R1 sync latency", lat, 3);
      chk(fd == ~(7'(1) << VEC[v][2:0]), "R2 R3 winner", fd, ~(7'(1) << VEC[v][2:0]));
      chk(len == XLEN, "R4 transfer length", len, XLEN);
      chk(st && !tcf, "R8 no tc mid-block", int'(tcf), 0);
      quiet(6, "R5 idle outputs");
    end

    // R7: zero load disables
    load(2, 0);
    dreq = 7'b0000100;
    quiet(12, "R7 zero load disables");
    dreq = '0;
    repeat (4) @(negedge clk);

    // R8 R9 R10: two-transfer block on channel 3
    load(3, 2);
    dreq = 7'b0001000;
    run_xfer(7'b0001000, lat, fd, len, tcf, st);
    chk(!tcf && st, "R8 first of two no tc", int'(tcf), 0);
    chk(!aen, "R10 idle after transfer", int'(aen), 0);
    run_xfer(7'b0001000, lat, fd, len, tcf, st);
    chk(lat >= 1, "R10 idle gap", lat, 1);
    chk(tcf && st && len == XLEN, "R8 tc on final transfer", int'(tcf), 1);
    chk(fd == 7'b1110111, "R3 dack ch3", fd, 7'h77);
    quiet(15, "R9 exhausted channel not granted");
    // R7 reload re-enables
    load(3, 1);
    run_xfer('0, lat, fd, len, tcf, st);
    chk(fd == 7'b1110111 && tcf, "R7 reload grants with tc", {fd, tcf}, {7'h77, 1'b1});
    repeat (4) @(negedge clk);

    // R6: higher priority arrives mid-transfer
    dreq = 7'b0100000;
    run_xfer(7'b0100001, lat, fd, len, tcf, st);
    chk(fd == 7'b1011111 && st, "R6 grant held", fd, 7'h5f);
    run_xfer('0, lat, fd, len, tcf, st);
    chk(fd == 7'b1111110, "R6 R2 next winner ch0", fd, 7'h7e);
    repeat (6) @(negedge clk);

    // R5 reset mid-transfer
    dreq = 7'b0000001;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dack_n == '1 && !aen && !tc, "R5 async reset clears", {dack_n, aen}, {7'h7f, 1'b0});
    dreq = '0;
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule